// File: doc/BRIEF.md
# Stereo LSB-Aligned Serial Audio Transmitter

This block is the transmit half of a serial audio port acting as bus master. It generates the bit clock, the channel select line and the serial data line for a stereo stream. Each channel occupies a fixed 32-bit slot: the left channel goes first and the right channel second. The sample is placed at the far end of its slot, so zero bits fill the front of the slot and the sample's least significant bit is the last bit of the slot. Bits go out most significant first. Software-side logic feeds samples through a 16-bit write port into a one-sample staging register. A status output shows when that register can take the next write.

Two packet types are supported. In 16-bit mode, one write supplies a whole slot and the block supplies 16 leading zeros. In 24-bit mode, a slot needs two writes. The first write carries the top byte of the sample in its low 8 bits, and the second carries the low 16 bits. The block supplies 8 leading zeros. A run-time input picks the idle level of the bit clock, which swaps the roles of its two edges. When a slot begins before its sample is complete, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `lsbj_audio_tx`

## Requirements
- R1: While enabled, the block sends frames of 64 bit periods. Bit periods 0 to 31 form the left slot and 32 to 63 the right slot. Each slot is shifted out most significant bit first.
- R2: With `pkt24` low, each slot is 16 zero bits followed by bits [15:0] of the one write that staged it.
- R3: With `pkt24` high, each slot is 8 zero bits followed by a 24-bit sample. The first write supplies sample bits [23:16] in its bits [7:0], and its bits [15:8] are ignored. The second write supplies sample bits [15:0].
- R4: `ws` is 0 for the left slot and 1 for the right slot. It switches at the start of the last bit period of the preceding slot, so it is 1 during bit periods 31 to 62 and 0 otherwise.
- R5: A bit period lasts 2*HALF_DIV clock cycles. With `ck_idle_high` low, `sck` is low in the first half of each bit period and high in the second half, and `sd` changes only at the falling edge. With `ck_idle_high` high, `sck` is inverted and the sampling edge is the falling one. While disabled, `sck` rests at the level of `ck_idle_high`.
- R6: `tx_empty` is 1 whenever the staging register can accept a write. This includes the state after only the first of the two 24-bit writes. `tx_empty` is 0 while a complete sample waits. A write made while `tx_empty` is 0 has no effect.
- R7: If a slot starts without a complete staged sample, that slot is all zeros and `underrun` becomes 1. Any half-written 24-bit sample is discarded. `underrun` stays 1 while enabled and returns to 0 while `en` is low.
- R8: While `en` is low, `sd` and `ws` are 0 and writes are still staged. The clock cycle after `en` rises starts bit period 0 of a left slot, which carries the sample staged before enabling.
- R9: During reset, `sck` is 0, `ws` is 0, `sd` is 0, `tx_empty` is 1 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the serial lines idle |
| pkt24 | input | 1 | 0: 16-bit samples, 1: 24-bit samples in two writes |
| ck_idle_high | input | 1 | Bit clock idle level and edge polarity select |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_data | input | 16 | Write data |
| tx_empty | output | 1 | Staging register can accept a write |
| underrun | output | 1 | Sticky flag: a slot started without its sample |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, 0 left, 1 right |
| sd | output | 1 | Serial data |

## Verification
The bench builds the block with its defaults: HALF_DIV of 2, 32-bit slots, 16-bit writes, 24-bit samples and the two-write path enabled. With a four-cycle bit period, a full stereo frame takes 256 cycles. This lets every vector and directed case decode complete frames in both packet types and both clock polarities, while still leaving time to stage the right channel after the left slot has started. With the two-write path built in, the half-written sample, the ignored upper byte and the partial-discard behaviour at an underrun can all be reached.

// File: rtl/lsbj_pkg.sv
package lsbj_pkg;
   typedef enum logic {
      PKT_16 = 1'b0,
      PKT_24 = 1'b1
   } pkt_e;

   function automatic int unsigned lsbj_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/lsbj_clkgen.sv
module lsbj_clkgen #(
   parameter int unsigned HALF_DIV  = 2,
   parameter int unsigned SLOT_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ck_idle_high,
   output logic run,
   output logic bit_adv,
   output logic load,
   output logic sck,
   output logic ws
);
   localparam int unsigned PER   = 2 * HALF_DIV;
   localparam int unsigned PH_W  = lsbj_pkg::lsbj_bits(PER);
   localparam int unsigned SB_W  = lsbj_pkg::lsbj_bits(SLOT_BITS);
   localparam int unsigned BI_W  = SB_W + 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF_DIV);

   logic              run_q;
   logic [PH_W-1:0]   ph_q;
   logic [BI_W-1:0]   bidx_q;
   logic [BI_W-1:0]   bidx_nxt;
   logic              slot_end;
   logic              hi_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ph_q   <= '0;
         bidx_q <= '0;
      end else if (!en) begin
         run_q  <= 1'b0;
         ph_q   <= '0;
         bidx_q <= '0;
      end else if (!run_q) begin
         run_q  <= 1'b1;
         ph_q   <= '0;
         bidx_q <= '0;
      end else if (ph_q == PH_LAST) begin
         ph_q   <= '0;
         bidx_q <= bidx_nxt;
      end else begin
         ph_q   <= ph_q + 1'b1;
      end
   end

   assign bidx_nxt = bidx_q + 1'b1;
   assign slot_end = (bidx_q[SB_W-1:0] == {SB_W{1'b1}});
   assign bit_adv  = run_q && (ph_q == PH_LAST);
   assign load     = en && (!run_q || (bit_adv && slot_end));
   assign hi_half  = run_q && (ph_q >= PH_MID);
   assign sck      = ck_idle_high ^ hi_half;
   assign ws       = run_q && bidx_nxt[BI_W-1];
   assign run      = run_q;
endmodule

// File: rtl/lsbj_stage.sv
module lsbj_stage #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned SAMPLE_W   = 24,
   parameter bit          SUPPORT_24 = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pkt24,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                take,
   output logic [SAMPLE_W-1:0] smp,
   output logic                full,
   output logic                tx_empty
);
   localparam int unsigned HI_W = SAMPLE_W - WORD_W;

   logic [SAMPLE_W-1:0] data_q, data_d;
   logic                full_q, full_d;
   logic                half_q, half_d;
   logic                accept;

   assign accept = wr_en && !full_q;

   generate
      if (SUPPORT_24) begin : g_two_write
         always_comb begin
            data_d = data_q;
            full_d = full_q;
            half_d = half_q;
            if (take) begin
               full_d = 1'b0;
               half_d = 1'b0;
            end
            if (accept) begin
               if (lsbj_pkg::pkt_e'(pkt24) == lsbj_pkg::PKT_24) begin
                  if (!half_d) begin
                     data_d[SAMPLE_W-1:WORD_W] = wr_data[HI_W-1:0];
                     half_d = 1'b1;
                  end else begin
                     data_d[WORD_W-1:0] = wr_data;
                     half_d = 1'b0;
                     full_d = 1'b1;
                  end
               end else begin
                  data_d = {{HI_W{1'b0}}, wr_data};
                  half_d = 1'b0;
                  full_d = 1'b1;
               end
            end
         end
      end else begin : g_one_write
         logic unused_mode;
         assign unused_mode = pkt24;
         always_comb begin
            data_d = data_q;
            full_d = full_q;
            half_d = 1'b0;
            if (take) full_d = 1'b0;
            if (accept) begin
               data_d = {{HI_W{1'b0}}, wr_data};
               full_d = 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         half_q <= 1'b0;
      end else begin
         data_q <= data_d;
         full_q <= full_d;
         half_q <= half_d;
      end
   end

   assign smp      = data_q;
   assign full     = full_q;
   assign tx_empty = !full_q;
endmodule

// File: rtl/lsbj_shifter.sv
module lsbj_shifter #(
   parameter int unsigned SLOT_BITS = 32,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SAMPLE_W  = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                load,
   input  logic                have,
   input  logic                pkt24,
   input  logic                shift,
   input  logic [SAMPLE_W-1:0] smp,
   output logic                sd
);
   logic [SLOT_BITS-1:0] pad16, pad24, sreg_q;

   genvar gi;
   generate
      for (gi = 0; gi < SLOT_BITS; gi++) begin : g_pad
         if (gi < WORD_W) begin : g_lo
            assign pad16[gi] = smp[gi];
         end else begin : g_lo_z
            assign pad16[gi] = 1'b0;
         end
         if (gi < SAMPLE_W) begin : g_wide
            assign pad24[gi] = smp[gi];
         end else begin : g_wide_z
            assign pad24[gi] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (!en) begin
         sreg_q <= '0;
      end else if (load) begin
         if (!have)      sreg_q <= '0;
         else if (pkt24) sreg_q <= pad24;
         else            sreg_q <= pad16;
      end else if (shift) begin
         sreg_q <= {sreg_q[SLOT_BITS-2:0], 1'b0};
      end
   end

   assign sd = sreg_q[SLOT_BITS-1];
endmodule

// File: rtl/lsbj_audio_tx.sv
module lsbj_audio_tx #(
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned SLOT_BITS  = 32,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned SAMPLE_W   = 24,
   parameter bit          SUPPORT_24 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pkt24,
   input  logic              ck_idle_high,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              tx_empty,
   output logic              underrun,
   output logic              sck,
   output logic              ws,
   output logic              sd
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if ((SLOT_BITS & (SLOT_BITS - 1)) != 0 || SLOT_BITS < 2) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two");
      end
      if (SAMPLE_W <= WORD_W || SAMPLE_W > 2 * WORD_W) begin : g_bad_sample
         $error("SAMPLE_W must lie above WORD_W and within two writes");
      end
      if (SLOT_BITS < SAMPLE_W) begin : g_bad_fit
         $error("SLOT_BITS must hold a full sample");
      end
   endgenerate

   logic                run;
   logic                bit_adv;
   logic                load;
   logic                stg_full;
   logic [SAMPLE_W-1:0] smp;
   logic                mode24;
   logic                urun_q;

   assign mode24 = SUPPORT_24 ? pkt24 : 1'b0;

   lsbj_clkgen #(
      .HALF_DIV  (HALF_DIV),
      .SLOT_BITS (SLOT_BITS)
   ) u_clk (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .ck_idle_high (ck_idle_high),
      .run          (run),
      .bit_adv      (bit_adv),
      .load         (load),
      .sck          (sck),
      .ws           (ws)
   );

   lsbj_stage #(
      .WORD_W     (WORD_W),
      .SAMPLE_W   (SAMPLE_W),
      .SUPPORT_24 (SUPPORT_24)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt24    (pkt24),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .take     (load),
      .smp      (smp),
      .full     (stg_full),
      .tx_empty (tx_empty)
   );

   lsbj_shifter #(
      .SLOT_BITS (SLOT_BITS),
      .WORD_W    (WORD_W),
      .SAMPLE_W  (SAMPLE_W)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .load  (load),
      .have  (stg_full),
      .pkt24 (mode24),
      .shift (bit_adv),
      .smp   (smp),
      .sd    (sd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                urun_q <= 1'b0;
      else if (!en)              urun_q <= 1'b0;
      else if (load && !stg_full) urun_q <= 1'b1;
   end

   assign underrun = urun_q;
endmodule

// File: rtl/lsbj_audio_tx_chk.sv
module lsbj_audio_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic ck_idle_high,
   input logic wr_en,
   input logic run,
   input logic bit_adv,
   input logic load,
   input logic stg_full,
   input logic tx_empty,
   input logic underrun,
   input logic sck,
   input logic ws,
   input logic sd
);
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !$past(en)) |-> (sck == ck_idle_high && !ws && !sd)); // R5

   AST_WS_HOLDS_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && en && !bit_adv) |=> $stable(ws)); // R4

   AST_SD_HOLDS_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && en && !bit_adv) |=> $stable(sd)); // R5

   AST_STAGED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty && !load) |=> !tx_empty); // R6

   AST_UNDERRUN_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !stg_full) |=> (!sd && underrun)); // R7

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && en) |=> underrun); // R7

   AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty == !stg_full)); // R6

   AST_START_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run) |=> (run && !ws)); // R8

   logic unused_wr;
   assign unused_wr = wr_en;
endmodule

bind lsbj_audio_tx lsbj_audio_tx_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .ck_idle_high (ck_idle_high),
   .wr_en        (wr_en),
   .run          (run),
   .bit_adv      (bit_adv),
   .load         (load),
   .stg_full     (stg_full),
   .tx_empty     (tx_empty),
   .underrun     (underrun),
   .sck          (sck),
   .ws           (ws),
   .sd           (sd)
);

// File: tb/lsbj_audio_tx_tb_top.sv
`timescale 1ns/1ps
module lsbj_audio_tx_tb_top;
   localparam int HALF_DIV = 2;
   localparam int NVEC = 4;
   // {pkt24, idle_high, L_hi, L_lo, R_hi, R_lo}
   localparam logic [65:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 16'h0000, 16'hA5C3, 16'h0000, 16'h1234},
      {1'b0, 1'b1, 16'h0000, 16'h8001, 16'h0000, 16'hFFFF},
      {1'b1, 1'b0, 16'hFF9A, 16'hBCDE, 16'h0012, 16'h3456},
      {1'b1, 1'b1, 16'h3C80, 16'h0001, 16'hA57F, 16'hFFFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, pkt24 = 1'b0, ck_idle_high = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic tx_empty, underrun, sck, ws, sd;

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lsbj_audio_tx dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .pkt24(pkt24),
      .ck_idle_high(ck_idle_high), .wr_en(wr_en), .wr_data(wr_data),
      .tx_empty(tx_empty), .underrun(underrun), .sck(sck), .ws(ws), .sd(sd)
   );

   // serial decoder
   logic        rx_on = 1'b0, prev_sck = 1'b0;
   int          rx_idx = 0, ws_err = 0, per_err = 0, gap = 0;
   logic [63:0] rx_frame = '0;

   always @(posedge clk) begin
      #2;
      if (rx_on) begin
         gap++;
         if ((!ck_idle_high && !prev_sck && sck) || (ck_idle_high && prev_sck && !sck)) begin
            rx_frame = {rx_frame[62:0], sd};
            if (ws != (rx_idx >= 31 && rx_idx <= 62)) ws_err++;
            if (rx_idx > 0 && gap != 2 * HALF_DIV) per_err++;
            gap = 0;
            rx_idx++;
            if (rx_idx == 64) rx_on = 1'b0;
         end
      end
      prev_sck = sck;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      while (!tx_empty) @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic start_rx();
      @(negedge clk);
      rx_frame = '0; rx_idx = 0; ws_err = 0; per_err = 0; gap = 0;
      prev_sck = sck;
      rx_on = 1'b1; en = 1'b1;
   endtask

   task automatic finish_rx(output logic urun_seen);
      wait (rx_idx == 64);
      @(negedge clk);
      urun_seen = underrun;
      en = 1'b0;
      chk(ws_err == 0, "R4 ws timing", 32'(ws_err), 32'd0);
      chk(per_err == 0, "R5 bit period", 32'(per_err), 32'd0);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] expect_slot(input logic m24, input logic [15:0] hi, input logic [15:0] lo);
      return m24 ? {8'h00, hi[7:0], lo} : {16'h0000, lo};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic u;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(sck == 1'b0, "R9 sck", 32'(sck), 32'd0);
      chk(ws == 1'b0, "R9 ws", 32'(ws), 32'd0);
      chk(sd == 1'b0, "R9 sd", 32'(sd), 32'd0);
      chk(tx_empty == 1'b1, "R9 tx_empty", 32'(tx_empty), 32'd1);
      chk(underrun == 1'b0, "R9 underrun", 32'(underrun), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         logic m24;
         logic [15:0] lh, ll, rh, rl;
         {m24, ck_idle_high, lh, ll, rh, rl} = VEC[v];
         pkt24 = m24;
         repeat (2) @(negedge clk);
         chk(sck == ck_idle_high, "R5 idle level", 32'(sck), 32'(ck_idle_high));
         chk(ws == 1'b0 && sd == 1'b0, "R8 idle lines", {30'd0, ws, sd}, 32'd0);
         if (m24) begin
            wr(lh);
            chk(tx_empty == 1'b1, "R6 half staged still empty", 32'(tx_empty), 32'd1);
         end
         wr(ll);
         chk(tx_empty == 1'b0, "R6 full after sample", 32'(tx_empty), 32'd0);
         start_rx();
         if (m24) wr(rh);
         wr(rl);
         finish_rx(u);
         chk(u == 1'b0, "R7 no underrun when fed", 32'(u), 32'd0);
         chk(rx_frame[63:32] == expect_slot(m24, lh, ll), m24 ? "R3 left slot" : "R2 left slot R1 R8",
             rx_frame[63:32], expect_slot(m24, lh, ll));
         chk(rx_frame[31:0] == expect_slot(m24, rh, rl), m24 ? "R3 right slot R1" : "R2 right slot",
             rx_frame[31:0], expect_slot(m24, rh, rl));
      end

      // R7 underrun with nothing staged
      pkt24 = 1'b0; ck_idle_high = 1'b0;
      start_rx();
      finish_rx(u);
      chk(rx_frame == 64'd0, "R7 underrun zeros", rx_frame[63:32] | rx_frame[31:0], 32'd0);
      chk(u == 1'b1, "R7 underrun sticky", 32'(u), 32'd1);
      chk(underrun == 1'b0, "R7 clear when disabled", 32'(underrun), 32'd0);

      // R6 write while full ignored
      wr(16'h1111);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h2222;
      @(negedge clk);
      wr_en = 1'b0;
      start_rx();
      wr(16'h3333);
      finish_rx(u);
      chk(rx_frame[63:32] == 32'h0000_1111, "R6 write while full ignored", rx_frame[63:32], 32'h0000_1111);
      chk(rx_frame[31:0] == 32'h0000_3333, "R6 next sample", rx_frame[31:0], 32'h0000_3333);

      // R7 partial 24-bit sample discarded at slot start
      pkt24 = 1'b1;
      wr(16'h0077);
      start_rx();
      wr(16'h0011);
      wr(16'h2233);
      finish_rx(u);
      chk(rx_frame[63:32] == 32'd0, "R7 partial discarded", rx_frame[63:32], 32'd0);
      chk(rx_frame[31:0] == 32'h0011_2233, "R7 R3 order kept", rx_frame[31:0], 32'h0011_2233);
      chk(u == 1'b1, "R7 partial flags underrun", 32'(u), 32'd1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule